// File: doc/BRIEF.md
# Per-Peripheral Privilege Access Checker

This block sits between a simple single-cycle bus master and a bank of peripherals. Every request carries an address and a privilege attribute. The block takes the target peripheral from the address and looks up one bit for that peripheral in a protection mask. When the bit is set, only privileged requests may reach the peripheral. An unprivileged request to a protected peripheral is stopped before it reaches the peripheral: a write is dropped, a read returns zero, and the error flag rises in the same cycle. The block adds no wait states.

Each peripheral is visible through four address windows: its plain window and three alias windows that set, clear or toggle bits. All four windows map to the same peripheral index, so they are all governed by the same mask bit. The first fault is latched in a status register together with the peripheral index. A level interrupt, gated by an enable bit, stays high until software clears the latched flag. The block's own registers accept privileged requests only. Any unprivileged request to them is refused and logged with the reserved index 31. After reset the mask is empty, so nothing is restricted.

Top module: `priv_gate`

## Requirements
- R1: After reset, the protection mask is all zero, the interrupt enable is 0, the status reads 0 and `irq` is low, so every peripheral access is allowed.
- R2: A request to a peripheral whose mask bit is 0 is forwarded in the same cycle, whatever its privilege. `per_valid` is high, `per_addr` equals `req_addr`, `rsp_err` is low and a read returns `per_rdata`.
- R3: A privileged request to a peripheral whose mask bit is 1 is forwarded exactly as in R2.
- R4: An unprivileged request to a peripheral whose mask bit is 1 keeps `per_valid` low and raises `rsp_err`. A read returns zero and a write is dropped.
- R5: Peripheral-space addresses have bit 17 = 0. Bits 16:15 select the window (0 plain, 1 set, 2 clear, 3 toggle), bits 14:10 are the peripheral index, and bits 9:0 are the offset inside the slot. All four windows of one index are checked against that index's single mask bit.
- R6: The status word at register offset 2 has its valid flag in bit 8 and the faulting index in bits 4:0. The first fault sets them. Later faults leave them unchanged while the flag is set.
- R7: A privileged write to the status word with bit 8 set clears the valid flag.
- R8: `irq` is high exactly when the valid flag is set and the enable bit (bit 0 of register offset 1) is set. It stays high until the flag is cleared.
- R9: Register space is bit 17 = 1, and the word offset is in bits 3:2: 0 is the mask, 1 is the enable, 2 is the status and 3 reads zero. Register requests are never forwarded. Unprivileged register requests get `rsp_err`, a read returns zero, a write is dropped, and the fault is logged with index 31.
- R10: The error flag and the read data belong to the same cycle as `req_valid`. No wait state is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged master |
| req_addr | input | 18 | Request address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data returned this cycle |
| rsp_err | output | 1 | Request refused this cycle |
| per_valid | output | 1 | Forwarded request to peripherals |
| per_write | output | 1 | Forwarded write flag |
| per_addr | output | 18 | Forwarded address |
| per_wdata | output | 32 | Forwarded write data |
| per_rdata | input | 32 | Read data from the addressed peripheral |
| irq | output | 1 | Level fault interrupt |

## Verification
The assertions assume that request inputs change only away from the rising edge and hold steady across it. They also assume that one request is in flight per cycle, so a status clear and a new fault never fall in the same cycle. The bench drives every request on the falling edge and issues one request per cycle. It samples the combinational response mid-cycle and the registered status after the edge. Random traffic covers mixed privileged and unprivileged requests to all four windows and to register space. Directed sequences then set up alias hits, repeated faults, clearing and blocked register writes.

// File: rtl/priv_gate_pkg.sv
// Package: shared constants for the privilege access checker.
// Assumes a 32-bit data bus; register offsets are word offsets.
package priv_gate_pkg;
    localparam int unsigned DATA_W         = 32;
    localparam int unsigned ALIAS_W        = 2;
    localparam int unsigned REG_OFF_W      = 2;
    localparam int unsigned STAT_VALID_BIT = 8;

    // Word offsets inside the checker's own register space.
    localparam logic [REG_OFF_W-1:0] REG_MASK  = 2'd0;
    localparam logic [REG_OFF_W-1:0] REG_IRQEN = 2'd1;
    localparam logic [REG_OFF_W-1:0] REG_STAT  = 2'd2;

    // Address window selected by the alias field.
    typedef enum logic [ALIAS_W-1:0] {
        WIN_PLAIN  = 2'd0,
        WIN_SET    = 2'd1,
        WIN_CLEAR  = 2'd2,
        WIN_TOGGLE = 2'd3
    } win_e;
endpackage

// File: rtl/priv_gate_decode.sv
// Address decoder: splits a request address into register-space select,
// peripheral index and register word offset. The alias field is removed
// on purpose, so every window of a peripheral yields the same index.
// Assumes the layout {regsel, alias[1:0], index, slot offset}.
module priv_gate_decode
    import priv_gate_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 10,
    parameter int unsigned IDX_W     = 5,
    localparam int unsigned WIN_LSB  = SLOT_BITS + IDX_W,
    localparam int unsigned REG_BIT  = WIN_LSB + ALIAS_W,
    localparam int unsigned AW       = REG_BIT + 1
) (
    input  logic [AW-1:0]        addr,
    output logic                 is_reg,
    output logic [IDX_W-1:0]     idx,
    output logic [REG_OFF_W-1:0] reg_off
);
    win_e window;
    logic unused_bits;

    // Field extraction; the window is only decoded, never used for the check.
    always_comb begin
        is_reg  = addr[REG_BIT];
        idx     = addr[SLOT_BITS +: IDX_W];
        reg_off = addr[2 +: REG_OFF_W];
        window  = win_e'(addr[WIN_LSB +: ALIAS_W]);
    end

    assign unused_bits = ^{window, addr[1:0], addr[SLOT_BITS-1:2+REG_OFF_W]};
endmodule

// File: rtl/priv_gate_check.sv
// Access decision: compares the request privilege with the mask bit of the
// addressed peripheral. Register-space requests need privilege always.
// Pure combinational; assumes inputs are stable for the whole cycle.
module priv_gate_check #(
    parameter int unsigned NUM_PERIPH = 32,
    localparam int unsigned IDX_W     = $clog2(NUM_PERIPH)
) (
    input  logic                  req_valid,
    input  logic                  req_priv,
    input  logic                  is_reg,
    input  logic [IDX_W-1:0]      idx,
    input  logic [NUM_PERIPH-1:0] mask,
    output logic                  allow,
    output logic                  fault,
    output logic [IDX_W-1:0]      fault_idx
);
    localparam logic [IDX_W-1:0] RSVD_IDX = IDX_W'(NUM_PERIPH - 1);

    // Decide allow/deny and the index to log on a refusal.
    always_comb begin
        if (is_reg) begin
            allow     = req_priv;
            fault_idx = RSVD_IDX;
        end else begin
            allow     = req_priv | ~mask[idx];
            fault_idx = idx;
        end
        fault = req_valid & ~allow;
    end
endmodule

// File: rtl/priv_gate_regs.sv
// Register bank: per-peripheral protection mask, interrupt enable and
// the read mux for the status word. Writes arrive pre-qualified
// (privileged, register space). Assumes NUM_PERIPH <= DATA_W.
module priv_gate_regs
    import priv_gate_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 32,
    localparam int unsigned IDX_W     = $clog2(NUM_PERIPH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_OFF_W-1:0]  reg_off,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  fault_valid,
    input  logic [IDX_W-1:0]      fault_idx,
    output logic [NUM_PERIPH-1:0] mask,
    output logic                  irq_en,
    output logic                  stat_clr,
    output logic [DATA_W-1:0]     rdata
);
    logic mask_we;
    logic en_we;

    // Write strobes per register.
    always_comb begin
        mask_we  = wr_en && (reg_off == REG_MASK);
        en_we    = wr_en && (reg_off == REG_IRQEN);
        stat_clr = wr_en && (reg_off == REG_STAT) && wdata[STAT_VALID_BIT];
    end

    // One flop per peripheral protection bit.
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)       mask[i] <= 1'b0;
            else if (mask_we) mask[i] <= wdata[i];
        end
    end

    // Interrupt enable flop.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_en <= 1'b0;
        else if (en_we) irq_en <= wdata[0];
    end

    // Read mux over the register words.
    always_comb begin
        rdata = '0;
        unique case (reg_off)
            REG_MASK:  rdata = DATA_W'(mask);
            REG_IRQEN: rdata = DATA_W'(irq_en);
            REG_STAT:  rdata = DATA_W'(fault_idx)
                             | (DATA_W'(fault_valid) << STAT_VALID_BIT);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/priv_gate_faultlog.sv
// Fault log: captures the index of the first refused request and holds it
// until software clears the flag. Assumes a clear and a new fault never
// coincide (one bus request per cycle); the clear wins if they do.
module priv_gate_faultlog #(
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault,
    input  logic [IDX_W-1:0] fault_idx_in,
    input  logic             clr,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    // Sticky first-fault capture with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            idx   <= '0;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (fault && !valid) begin
            valid <= 1'b1;
            idx   <= fault_idx_in;
        end
    end
endmodule

// File: rtl/priv_gate.sv
// Top: per-peripheral privilege gate on a single-cycle bus. Decodes the
// target, applies the one-bit-per-peripheral mask, forwards allowed
// peripheral requests, answers register requests locally and logs faults.
// Assumes one request per cycle and a peripheral that answers reads in the
// same cycle. No wait states are added.
module priv_gate
    import priv_gate_pkg::*;
#(
    parameter int unsigned NUM_PERIPH = 32,
    parameter int unsigned SLOT_BITS  = 10,
    localparam int unsigned IDX_W     = $clog2(NUM_PERIPH),
    localparam int unsigned AW        = SLOT_BITS + IDX_W + ALIAS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              per_valid,
    output logic              per_write,
    output logic [AW-1:0]     per_addr,
    output logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] per_rdata,
    output logic              irq
);
    logic                  is_reg;
    logic [IDX_W-1:0]      dec_idx;
    logic [REG_OFF_W-1:0]  reg_off;
    logic [NUM_PERIPH-1:0] priv_mask;
    logic                  irq_en;
    logic                  allow;
    logic                  fault;
    logic [IDX_W-1:0]      fault_idx_new;
    logic                  fault_valid;
    logic [IDX_W-1:0]      fault_idx;
    logic                  stat_clr;
    logic                  reg_wr;
    logic [DATA_W-1:0]     reg_rdata;

    priv_gate_decode #(.SLOT_BITS(SLOT_BITS), .IDX_W(IDX_W)) u_decode (
        .addr    (req_addr),
        .is_reg  (is_reg),
        .idx     (dec_idx),
        .reg_off (reg_off)
    );

    priv_gate_check #(.NUM_PERIPH(NUM_PERIPH)) u_check (
        .req_valid (req_valid),
        .req_priv  (req_priv),
        .is_reg    (is_reg),
        .idx       (dec_idx),
        .mask      (priv_mask),
        .allow     (allow),
        .fault     (fault),
        .fault_idx (fault_idx_new)
    );

    // Register writes only for allowed (hence privileged) register requests.
    assign reg_wr = req_valid && req_write && is_reg && allow;

    priv_gate_regs #(.NUM_PERIPH(NUM_PERIPH)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .reg_off     (reg_off),
        .wdata       (req_wdata),
        .fault_valid (fault_valid),
        .fault_idx   (fault_idx),
        .mask        (priv_mask),
        .irq_en      (irq_en),
        .stat_clr    (stat_clr),
        .rdata       (reg_rdata)
    );

    priv_gate_faultlog #(.IDX_W(IDX_W)) u_log (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault        (fault),
        .fault_idx_in (fault_idx_new),
        .clr          (stat_clr),
        .valid        (fault_valid),
        .idx          (fault_idx)
    );

    // Forwarding path and same-cycle response.
    always_comb begin
        per_valid = req_valid && allow && !is_reg;
        per_write = req_write;
        per_addr  = req_addr;
        per_wdata = req_wdata;
        rsp_err   = fault;
        if (!req_valid || !allow) rsp_rdata = '0;
        else if (is_reg)          rsp_rdata = reg_rdata;
        else                      rsp_rdata = per_rdata;
    end

    // Level interrupt from the latched flag.
    assign irq = fault_valid && irq_en;
endmodule

// File: rtl/priv_gate_sva.sv
// Checker: temporal properties of the privilege gate, bound to the top.
// Assumes request inputs are stable around the rising clock edge.
module priv_gate_sva #(
    parameter int unsigned NUM_PERIPH = 32,
    parameter int unsigned SLOT_BITS  = 10,
    localparam int unsigned IDX_W     = $clog2(NUM_PERIPH),
    localparam int unsigned REG_BIT   = SLOT_BITS + IDX_W + 2,
    localparam int unsigned AW        = REG_BIT + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic                  req_priv,
    input logic [AW-1:0]         req_addr,
    input logic [31:0]           rsp_rdata,
    input logic                  rsp_err,
    input logic                  per_valid,
    input logic                  irq,
    input logic [NUM_PERIPH-1:0] mask,
    input logic                  fault_valid,
    input logic [IDX_W-1:0]      fault_idx
);
    logic             unused_addr;
    logic [IDX_W-1:0] a_idx;
    assign unused_addr = ^req_addr;
    assign a_idx = req_addr[SLOT_BITS +: IDX_W];

    a_r2_open_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_addr[REG_BIT] && !mask[a_idx]) |-> (per_valid && !rsp_err));

    a_r4_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_priv && !req_addr[REG_BIT] && mask[a_idx])
        |-> (!per_valid && rsp_err && rsp_rdata == 32'd0));

    a_r6_first_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && $past(fault_valid)) |-> (fault_idx == $past(fault_idx)));

    a_r6_set_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_valid) |-> $past(rsp_err));

    a_r7_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_valid) |-> $past(req_valid && req_write && req_priv && req_addr[REG_BIT]));

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fault_valid);

    a_r9_reg_local: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[REG_BIT]) |-> !per_valid);

    a_r10_err_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> req_valid);
endmodule

bind priv_gate priv_gate_sva #(.NUM_PERIPH(NUM_PERIPH), .SLOT_BITS(SLOT_BITS)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_priv    (req_priv),
    .req_addr    (req_addr),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err),
    .per_valid   (per_valid),
    .irq         (irq),
    .mask        (priv_mask),
    .fault_valid (fault_valid),
    .fault_idx   (fault_idx)
);

// File: tb/priv_gate_bench.sv
module priv_gate_bench;
    localparam int AW = 18;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          req_valid, req_write, req_priv;
    logic [AW-1:0] req_addr;
    logic [31:0]   req_wdata, rsp_rdata, per_wdata, per_rdata;
    logic          rsp_err, per_valid, per_write, irq;
    logic [AW-1:0] per_addr;

    priv_gate u_priv_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_priv(req_priv), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .per_valid(per_valid),
        .per_write(per_write), .per_addr(per_addr), .per_wdata(per_wdata),
        .per_rdata(per_rdata), .irq(irq)
    );

    // Peripheral model: read data is a known function of the address.
    assign per_rdata = 32'hC0DE_0000 ^ 32'(per_addr);

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_mask;
    logic        m_en, m_fv;
    logic [4:0]  m_fidx;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] paddr(logic [1:0] win, logic [4:0] idx, logic [9:0] off);
        return {1'b0, win, idx, off};
    endfunction

    function automatic logic [AW-1:0] raddr(logic [1:0] off);
        return {1'b1, 13'd0, off, 2'b00};
    endfunction

    function automatic logic m_allowed(logic [AW-1:0] a, logic priv);
        if (a[17]) return priv;
        return priv | ~m_mask[a[14:10]];
    endfunction

    function automatic logic [31:0] m_regread(logic [1:0] off);
        case (off)
            2'd0:    return m_mask;
            2'd1:    return {31'd0, m_en};
            2'd2:    return {23'd0, m_fv, 3'd0, m_fidx};
            default: return 32'd0;
        endcase
    endfunction

    // One bus request; checks the same-cycle response and the post-edge state.
    task automatic acc(logic wr, logic priv, logic [AW-1:0] a, logic [31:0] wd, string tag_in);
        logic ok;
        string tag;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_priv = priv; req_addr = a; req_wdata = wd;
        #5;
        ok = m_allowed(a, priv);
        if (tag_in != "")      tag = tag_in;
        else if (a[17])        tag = "R9";
        else if (!ok)          tag = "R4";
        else if (m_mask[a[14:10]]) tag = "R3";
        else                   tag = "R2";
        // R10: response sampled inside the request cycle itself.
        chk(tag, "rsp_err (R10 same cycle)", 32'(rsp_err), 32'(!ok));
        chk(tag, "per_valid", 32'(per_valid), 32'(ok && !a[17]));
        if (ok && !a[17]) chk(tag, "per_addr", 32'(per_addr), 32'(a));
        if (!wr) begin
            if (!ok)        chk(tag, "rdata", rsp_rdata, 32'd0);
            else if (a[17]) chk(tag, "reg rdata", rsp_rdata, m_regread(a[3:2]));
            else            chk(tag, "periph rdata", rsp_rdata, 32'hC0DE_0000 ^ 32'(a));
        end
        @(posedge clk);
        if (!ok && !m_fv) begin
            m_fv = 1'b1;
            m_fidx = a[17] ? 5'd31 : a[14:10];
        end else if (ok && a[17] && wr) begin
            case (a[3:2])
                2'd0: m_mask = wd;
                2'd1: m_en = wd[0];
                2'd2: if (wd[8]) m_fv = 1'b0;
                default: ;
            endcase
        end
        #1;
        req_valid = 1'b0;
        chk("R8", "irq", 32'(irq), 32'(m_fv & m_en));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_priv = 1'b0;
        req_addr = '0; req_wdata = '0;
        m_mask = '0; m_en = 1'b0; m_fv = 1'b0; m_fidx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "irq in reset", 32'(irq), 32'd0);
        rst_n = 1'b1;

        // R1: reset contents, and open access for unprivileged masters.
        acc(1'b0, 1'b1, raddr(2'd0), 32'd0, "R1");
        acc(1'b0, 1'b1, raddr(2'd1), 32'd0, "R1");
        acc(1'b0, 1'b1, raddr(2'd2), 32'd0, "R1");
        acc(1'b0, 1'b0, paddr(2'd0, 5'd31, 10'h3FC), 32'd0, "R1");

        // R5: protect peripheral 7, unprivileged hits on every window are refused.
        acc(1'b1, 1'b1, raddr(2'd0), 32'h0000_0080, "R5");
        for (int w = 0; w < 4; w++) acc(1'b0, 1'b0, paddr(2'(w), 5'd7, 10'h010), 32'd0, "R5");
        for (int w = 0; w < 4; w++) acc(1'b1, 1'b1, paddr(2'(w), 5'd7, 10'h014), 32'h55, "R5");
        acc(1'b0, 1'b0, paddr(2'd3, 5'd6, 10'h010), 32'd0, "R5");

        // R6: the first fault (index 7) is held; a later fault on 9 does not replace it.
        acc(1'b1, 1'b1, raddr(2'd0), 32'h0000_0280, "R6");
        acc(1'b1, 1'b0, paddr(2'd1, 5'd9, 10'h0), 32'h1, "R6");
        acc(1'b0, 1'b1, raddr(2'd2), 32'd0, "R6");

        // R8: enable raises irq while the flag stays set.
        acc(1'b1, 1'b1, raddr(2'd1), 32'h1, "R8");
        acc(1'b0, 1'b1, raddr(2'd1), 32'd0, "R8");

        // R7: writing with bit 8 clear has no effect; bit 8 set clears.
        acc(1'b1, 1'b1, raddr(2'd2), 32'h0000_00FF, "R7");
        acc(1'b0, 1'b1, raddr(2'd2), 32'd0, "R7");
        acc(1'b1, 1'b1, raddr(2'd2), 32'h0000_0100, "R7");
        acc(1'b0, 1'b1, raddr(2'd2), 32'd0, "R7");

        // R9: unprivileged register write is dropped and logged with index 31.
        acc(1'b1, 1'b0, raddr(2'd0), 32'hFFFF_FFFF, "R9");
        acc(1'b0, 1'b1, raddr(2'd0), 32'd0, "R9");
        acc(1'b0, 1'b1, raddr(2'd2), 32'd0, "R9");
        acc(1'b0, 1'b0, raddr(2'd1), 32'd0, "R9");
        acc(1'b0, 1'b1, raddr(2'd3), 32'd0, "R9");
        acc(1'b1, 1'b1, raddr(2'd2), 32'h0000_0100, "R7");

        // Random traffic over register space and all windows.
        for (int i = 0; i < 600; i++) begin
            int r;
            logic wr, pv;
            logic [31:0] wd;
            r  = int'($urandom % 10);
            wr = 1'($urandom);
            wd = $urandom;
            if (r < 2) begin
                pv = ($urandom % 10) != 0;
                acc(wr, pv, raddr(2'($urandom)), wd, "");
            end else begin
                pv = 1'($urandom);
                acc(wr, pv, paddr(2'($urandom), 5'($urandom), 10'($urandom)), wd, "");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule